// File: doc/BRIEF.md
# S-Interface Receive Timing Recovery

This block produces the receive bit clock and the bit-sampling strobe for the line side of an S/T port that works as the network end. It runs from a system clock at 40 times the 192 kHz line bit rate. A locally generated transmit bit clock (40 ticks per bit, 48 bits per frame) is the timing reference for both modes.

`mode_bus` selects the receive clock source. When it is high (short passive bus), the receive clock is the transmit clock delayed by 35 ticks, and each bit is sampled on its rising edge. When it is low (point-to-point or extended passive bus), a free-running phase counter is nudged by at most one tick for each level change seen on `rx_data`. Bits are then sampled 30 ticks after each recovered rising edge. An external frame aligner pulses `rx_frame_mark`; the block records the transmit bit index at that moment as the receive-to-transmit frame offset and flags offsets outside the expected window.

Top module: `srx_timing_recovery`

## Requirements
- R1: `tx_clk` has a period of 40 ticks. It is high during transmit ticks 0 to 19 and low during ticks 20 to 39. Tick 0 is the first cycle after reset.
- R2: While `rst` is high, `rx_bit`, `ofs_valid`, `ofs_flag` and `ofs_bits` are 0, `rx_strobe` is 0, and `tx_clk` and `rx_clk` are 1.
- R3: With `mode_bus`=1, `rx_clk` equals `tx_clk` delayed by 35 ticks. `rx_strobe` is high only at transmit tick 35, which is the rising edge of `rx_clk`.
- R4: With `mode_bus`=1, level changes on `rx_data` have no effect on `rx_clk` or `rx_strobe`.
- R5: With `mode_bus`=0 and no change on `rx_data`, the recovered phase advances one tick per cycle (0..39). `rx_clk` is high for phases 0 to 19, and `rx_strobe` is high at phase 30.
- R6: With `mode_bus`=0, a change on `rx_data` seen at phase 1..19 holds the phase for one cycle. A change seen at phase 20..39 advances it by two. A change seen at phase 0 leaves it unchanged. No single change moves the phase by more than one tick.
- R7: With `mode_bus`=0 and one change per bit at a fixed position, the phase settles so that `rx_strobe` comes 30 ticks after each change.
- R8: When `rx_strobe` is high, `rx_bit` takes the value of `rx_data` in that cycle and shows it from the next cycle on. This also holds when a phase correction happens in the same cycle.
- R9: A pulse on `rx_frame_mark` loads `ofs_bits` with the transmit bit index (0..47) current in that cycle and sets `ofs_valid`, both visible in the next cycle. A mark in the last tick of a bit reports that bit, not the next one.
- R10: `ofs_flag` is loaded together with `ofs_bits`. With `mode_bus`=1 it is set when the offset is not 2. With `mode_bus`=0 it is set when the offset is below 2 or above 8, and an offset of 0 is still reported normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 40 ticks per line bit |
| rst | input | 1 | Synchronous active-high reset |
| mode_bus | input | 1 | 1 = short passive bus, 0 = point-to-point / extended bus |
| rx_data | input | 1 | Sliced receive line level |
| rx_frame_mark | input | 1 | One-cycle pulse from the frame aligner at a receive frame start |
| tx_clk | output | 1 | Transmit bit clock |
| rx_clk | output | 1 | Receive bit clock |
| rx_strobe | output | 1 | One-cycle receive sampling strobe |
| rx_bit | output | 1 | Last sampled receive bit |
| ofs_bits | output | 6 | Measured receive-to-transmit frame offset in bits |
| ofs_valid | output | 1 | Set once an offset has been measured |
| ofs_flag | output | 1 | Offset outside the window for the current mode |

## Verification
In point-to-point mode, the sampling strobe and a late-clock phase correction can fall in the same cycle. The bench provokes this by changing `rx_data` in the very cycle where `rx_strobe` is high at phase 30. It then expects `rx_bit` to hold the new level, and every later strobe to come one tick early, at tick 29 of each 40-tick period. A frame mark placed in the last tick of a transmit bit, together with the bit counter's advance, is a second coincidence. There the reported offset must still be the earlier bit.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int unsigned TICKS_PER_BIT = 40;
    localparam int unsigned BUS_DELAY     = 35;
    localparam int unsigned P2P_SAMPLE    = 30;
    localparam int unsigned FRAME_BITS    = 48;
    localparam int unsigned WIN_LO        = 2;
    localparam int unsigned WIN_HI        = 8;
    localparam int unsigned BUS_OFS       = 2;

    localparam int unsigned PH_W  = $clog2(TICKS_PER_BIT);
    localparam int unsigned BIT_W = $clog2(FRAME_BITS);

    typedef logic [PH_W-1:0]  phase_t;
    typedef logic [BIT_W-1:0] bitidx_t;

    localparam phase_t PH_ZERO = '0;
    localparam phase_t PH_ONE  = phase_t'(1);
    localparam phase_t PH_TWO  = phase_t'(2);
    localparam phase_t PH_HALF = phase_t'(TICKS_PER_BIT / 2);
    localparam phase_t PH_LAST = phase_t'(TICKS_PER_BIT - 1);
    localparam phase_t PH_PEN  = phase_t'(TICKS_PER_BIT - 2);
    localparam phase_t PH_BUSD = phase_t'(BUS_DELAY);
    localparam phase_t PH_BUSW = phase_t'(TICKS_PER_BIT - BUS_DELAY);
    localparam phase_t PH_SAMP = phase_t'(P2P_SAMPLE);

    localparam bitidx_t BI_ONE  = bitidx_t'(1);
    localparam bitidx_t BI_LAST = bitidx_t'(FRAME_BITS - 1);
    localparam bitidx_t BI_LO   = bitidx_t'(WIN_LO);
    localparam bitidx_t BI_HI   = bitidx_t'(WIN_HI);
    localparam bitidx_t BI_BUS  = bitidx_t'(BUS_OFS);

    typedef enum logic [1:0] {
        ADJ_NONE,
        ADJ_HOLD,
        ADJ_SKIP
    } adj_e;

    typedef struct packed {
        logic    valid;
        logic    flag;
        bitidx_t bits;
    } ofs_stat_t;

    // Advance a phase by one tick, or by two when skip is set, modulo a bit.
    function automatic phase_t phase_step(phase_t p, logic skip);
        phase_t r;
        if (p == PH_LAST)
            r = skip ? PH_ONE : PH_ZERO;
        else if (skip && p == PH_PEN)
            r = PH_ZERO;
        else
            r = p + (skip ? PH_TWO : PH_ONE);
        return r;
    endfunction

    // Receive phase in bus mode: the transmit phase minus the fixed delay.
    function automatic phase_t bus_phase(phase_t tx);
        return (tx >= PH_BUSD) ? (tx - PH_BUSD) : (tx + PH_BUSW);
    endfunction

    function automatic logic clk_level(phase_t p);
        return p < PH_HALF;
    endfunction

    function automatic logic ofs_outside(bitidx_t b, logic bus);
        return bus ? (b != BI_BUS) : ((b < BI_LO) || (b > BI_HI));
    endfunction

endpackage

// File: rtl/srx_tx_clkgen.sv
module srx_tx_clkgen
    import srx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    output phase_t  tx_ph,
    output bitidx_t tx_bit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ph  <= PH_ZERO;
            tx_bit <= '0;
        end else begin
            tx_ph <= phase_step(tx_ph, 1'b0);
            if (tx_ph == PH_LAST)
                tx_bit <= (tx_bit == BI_LAST) ? '0 : tx_bit + BI_ONE;
        end
    end

endmodule

// File: rtl/srx_phase_track.sv
module srx_phase_track
    import srx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adj_en,
    input  logic   rx_data,
    output phase_t rec_ph
);

    logic   prev_q;
    logic   edge_seen;
    adj_e   adj;
    phase_t ph_next;

    assign edge_seen = rx_data ^ prev_q;

    always_comb begin
        if (!adj_en || !edge_seen || rec_ph == PH_ZERO)
            adj = ADJ_NONE;
        else if (rec_ph < PH_HALF)
            adj = ADJ_HOLD;
        else
            adj = ADJ_SKIP;
    end

    always_comb begin
        case (adj)
            ADJ_HOLD: ph_next = rec_ph;
            ADJ_SKIP: ph_next = phase_step(rec_ph, 1'b1);
            default:  ph_next = phase_step(rec_ph, 1'b0);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_ph <= PH_ZERO;
            prev_q <= 1'b0;
        end else begin
            rec_ph <= ph_next;
            prev_q <= rx_data;
        end
    end

endmodule

// File: rtl/srx_frame_offset.sv
module srx_frame_offset
    import srx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      mode_bus,
    input  logic      mark,
    input  bitidx_t   tx_bit,
    output ofs_stat_t stat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else if (mark) begin
            stat.valid <= 1'b1;
            stat.bits  <= tx_bit;
            stat.flag  <= ofs_outside(tx_bit, mode_bus);
        end
    end

endmodule

// File: rtl/srx_timing_recovery.sv
module srx_timing_recovery
    import srx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_bus,
    input  logic                 rx_data,
    input  logic                 rx_frame_mark,
    output logic                 tx_clk,
    output logic                 rx_clk,
    output logic                 rx_strobe,
    output logic                 rx_bit,
    output logic [BIT_W-1:0]     ofs_bits,
    output logic                 ofs_valid,
    output logic                 ofs_flag
);

    phase_t    tx_ph;
    bitidx_t   tx_bit;
    phase_t    rec_ph;
    phase_t    rx_ph;
    phase_t    strobe_ph;
    ofs_stat_t stat;

    srx_tx_clkgen u_tx (
        .clk    (clk),
        .rst    (rst),
        .tx_ph  (tx_ph),
        .tx_bit (tx_bit)
    );

    srx_phase_track u_rec (
        .clk     (clk),
        .rst     (rst),
        .adj_en  (!mode_bus),
        .rx_data (rx_data),
        .rec_ph  (rec_ph)
    );

    srx_frame_offset u_ofs (
        .clk      (clk),
        .rst      (rst),
        .mode_bus (mode_bus),
        .mark     (rx_frame_mark),
        .tx_bit   (tx_bit),
        .stat     (stat)
    );

    assign rx_ph     = mode_bus ? bus_phase(tx_ph) : rec_ph;
    assign strobe_ph = mode_bus ? PH_ZERO : PH_SAMP;
    assign tx_clk    = clk_level(tx_ph);
    assign rx_clk    = clk_level(rx_ph);
    assign rx_strobe = !rst && (rx_ph == strobe_ph);

    always_ff @(posedge clk) begin
        if (rst)
            rx_bit <= 1'b0;
        else if (rx_strobe)
            rx_bit <= rx_data;
    end

    assign ofs_bits  = stat.bits;
    assign ofs_valid = stat.valid;
    assign ofs_flag  = stat.flag;

endmodule

// File: rtl/srx_timing_sva.sv
module srx_timing_sva
    import srx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             mode_bus,
    input logic             rx_data,
    input logic             rx_frame_mark,
    input logic             tx_clk,
    input logic             rx_clk,
    input logic             rx_strobe,
    input logic             rx_bit,
    input logic [BIT_W-1:0] ofs_bits,
    input logic             ofs_valid,
    input logic             ofs_flag
);

    // R2
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!ofs_valid && !rx_bit && !ofs_flag));

    // R3
    bus_strobe_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_bus && rx_strobe) |-> ($rose(rx_clk) && !tx_clk));

    // R5
    p2p_strobe_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_bus && rx_strobe) |-> !rx_clk);

    // R8
    rx_bit_capture_chk: assert property (@(posedge clk) disable iff (rst)
        rx_strobe |=> (rx_bit == $past(rx_data)));

    // R9
    ofs_update_chk: assert property (@(posedge clk) disable iff (rst)
        rx_frame_mark |=> ofs_valid);

    // R10
    bus_nominal_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_bus && ofs_valid && ofs_bits == BI_BUS) |-> !ofs_flag);

endmodule

bind srx_timing_recovery srx_timing_sva u_sva (.*);

// File: tb/srx_timing_recovery_tb_top.sv
module srx_timing_recovery_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_bus = 1'b0;
    logic       rx_data = 1'b0;
    logic       rx_frame_mark = 1'b0;
    logic       tx_clk, rx_clk, rx_strobe, rx_bit;
    logic [5:0] ofs_bits;
    logic       ofs_valid, ofs_flag;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    srx_timing_recovery dut_i (
        .clk           (clk),
        .rst           (rst),
        .mode_bus      (mode_bus),
        .rx_data       (rx_data),
        .rx_frame_mark (rx_frame_mark),
        .tx_clk        (tx_clk),
        .rx_clk        (rx_clk),
        .rx_strobe     (rx_strobe),
        .rx_bit        (rx_bit),
        .ofs_bits      (ofs_bits),
        .ofs_valid     (ofs_valid),
        .ofs_flag      (ofs_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s at cyc %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic do_reset(input logic bus);
        @(negedge clk);
        rst = 1'b1;
        mode_bus = bus;
        rx_data = 1'b0;
        rx_frame_mark = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_cyc(input int t);
        while (cyc != t) @(negedge clk);
    endtask

    function automatic int md(input int a);
        return ((a % 40) + 40) % 40;
    endfunction

    // R2
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 tx_clk", tx_clk, 1);
        check("R2 rx_clk", rx_clk, 1);
        check("R2 rx_strobe", rx_strobe, 0);
        check("R2 rx_bit", rx_bit, 0);
        check("R2 ofs_valid", ofs_valid, 0);
        check("R2 ofs_flag", ofs_flag, 0);
        check("R2 ofs_bits", ofs_bits, 0);
    endtask

    // R1
    task automatic t_txclk();
        do_reset(1'b0);
        repeat (100) begin
            @(negedge clk);
            check("R1 tx_clk", tx_clk, int'(md(cyc) < 20));
        end
    endtask

    // R3 R4
    task automatic t_bus();
        do_reset(1'b1);
        for (int i = 0; i < 130; i++) begin
            @(negedge clk);
            if (i % 7 == 3) rx_data = ~rx_data;
            check("R3 rx_clk", rx_clk, int'(md(cyc + 5) < 20));
            check("R4 rx_strobe", rx_strobe, int'(md(cyc) == 35));
        end
    endtask

    // R5
    task automatic t_p2p_free();
        do_reset(1'b0);
        repeat (100) begin
            @(negedge clk);
            check("R5 rx_clk", rx_clk, int'(md(cyc) < 20));
            check("R5 rx_strobe", rx_strobe, int'(md(cyc) == 30));
        end
    endtask

    // R6: one change seen at phase 10 holds, at phase 25 advances
    task automatic t_p2p_step(input int at, input int shift);
        do_reset(1'b0);
        wait_cyc(at);
        rx_data = 1'b1;
        repeat (100) begin
            @(negedge clk);
            check("R6 rx_strobe", rx_strobe, int'(md(cyc - shift) == 30));
        end
    endtask

    // R7 R8
    task automatic t_p2p_lock(input int d);
        int pend = 0;
        logic want = 1'b0;
        do_reset(1'b0);
        for (int n = 0; n < 40 * 30; n++) begin
            @(negedge clk);
            if (pend != 0) begin
                check("R8 rx_bit", rx_bit, int'(want));
                pend = 0;
            end
            if (md(cyc) == d) rx_data = ~rx_data;
            if (n >= 40 * 25)
                check("R7 rx_strobe", rx_strobe, int'(md(cyc - d) == 30));
            if (rx_strobe) begin
                want = rx_data;
                pend = 1;
            end
        end
    endtask

    // R8 R6: change arrives in the strobe cycle itself
    task automatic t_coincide();
        do_reset(1'b0);
        wait_cyc(30);
        check("R8 strobe before change", rx_strobe, 1);
        rx_data = 1'b1;
        @(negedge clk);
        check("R8 rx_bit same-cycle", rx_bit, 1);
        repeat (90) begin
            @(negedge clk);
            check("R6 strobe after same-cycle skip", rx_strobe, int'(md(cyc) == 29));
        end
    endtask

    task automatic mark_at(input int t, input int exp_bits, input int exp_flag, input string tag);
        wait_cyc(t);
        rx_frame_mark = 1'b1;
        @(negedge clk);
        rx_frame_mark = 1'b0;
        check({tag, " ofs_bits"}, ofs_bits, exp_bits);
        check({tag, " ofs_flag"}, ofs_flag, exp_flag);
        check({tag, " ofs_valid"}, ofs_valid, 1);
    endtask

    // R9 R10
    task automatic t_offset();
        do_reset(1'b0);
        mark_at(5, 0, 1, "R10 p2p zero");
        mark_at(85, 2, 0, "R9 p2p two");
        mark_at(359, 8, 0, "R9 last tick of bit 8");
        mark_at(360, 9, 1, "R10 p2p nine");
        mark_at(1885, 47, 1, "R9 bit 47");
        do_reset(1'b1);
        mark_at(85, 2, 0, "R10 bus two");
        mark_at(130, 3, 1, "R10 bus three");
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired at cyc %0d: actual 0 expected 1", cyc);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_txclk();
        t_bus();
        t_p2p_free();
        t_p2p_step(10, 1);
        t_p2p_step(25, -1);
        t_p2p_lock(10);
        t_p2p_lock(25);
        t_coincide();
        t_offset();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule